// File: doc/BRIEF.md
# USB Function Interrupt Status and Mask Register

This block holds the interrupt status byte of a USB function controller and the matching mask byte. Three sticky flags latch single-cycle event strobes from the serial engine: bus reset seen, an endpoint 2 IN token that found no transmit data ready, and a setup command accepted on endpoint 0. Two further bits are not latched. They show, one clock late, the level of the endpoint 1 receive-FIFO-full signal and the endpoint 2 transmit-space signal.

Software reads both bytes through a small register port. A sticky flag is cleared by writing 0 to its bit. Writing 1 leaves that bit alone, so a single write can clear one flag without touching the others. A bitwise AND of the status byte and the mask byte, reduced by OR, drives one registered interrupt request line.

Top module: `usb_irq_flag_reg`

## Requirements
- R1: With `rst` high at a clock edge, the status byte reads 0x10, the mask byte reads 0x00, `irq_o` is 0 and `rd_data_o` is 0x00.
- R2: A strobe on `ev_bus_reset_i` sets status bit 7. A strobe on `ev_setup_i` sets status bit 3. Both bits stay 1 until software clears them.
- R3: `ev_ep2_in_tok_i` sets status bit 5 only when `ep2_data_rdy_i` is 0 in the same cycle. A token that arrives while data is ready has no effect.
- R4: A write with `reg_sel_i`=0 clears each of bits 7, 5 and 3 whose write-data bit is 0, and leaves each such bit whose write-data bit is 1 unchanged.
- R5: When a set strobe and a clearing write hit the same sticky flag in the same cycle, the flag is 1 afterwards.
- R6: Bit 6 equals `ep1_rx_full_i` and bit 4 equals `ep2_tx_space_i`, each taken at the previous clock edge. Register writes never change these two bits.
- R7: Bits 2 to 0 of the status byte always read 0, and writes to them have no effect.
- R8: A write with `reg_sel_i`=1 loads all 8 bits of the mask byte, and the mask byte reads back unchanged.
- R9: `irq_o` after an edge equals the OR over all bits of (status AND mask) as they stood before that edge. It therefore falls one cycle after the last enabled pending bit clears.
- R10: `rd_data_o` after an edge holds the byte selected by `reg_sel_i` (0 = status, 1 = mask) as it stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel_i | input | 1 | Register select: 0 = status, 1 = mask |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| rd_data_o | output | 8 | Registered read data |
| ev_bus_reset_i | input | 1 | Bus reset detected strobe |
| ev_ep2_in_tok_i | input | 1 | Endpoint 2 IN token strobe |
| ep2_data_rdy_i | input | 1 | Endpoint 2 holds valid transmit data |
| ev_setup_i | input | 1 | Setup command accepted strobe |
| ep1_rx_full_i | input | 1 | Endpoint 1 FIFO holds received data |
| ep2_tx_space_i | input | 1 | An endpoint 2 transmit buffer can accept data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The case that is hardest to reach from the ports is a set strobe that lands in the same cycle as a write that clears the same flag. The stimulus builds this case on purpose for all three sticky flags. A long random phase then produces it many times, mixed in with tokens that arrive while data is ready or not ready. Throughout, a behavioural model predicts the read data and the request line on every clock, so that the interaction between the mask and the clears is also compared during changes of the live status bits.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int REG_W         = 8;
  localparam int BIT_BUS_RST   = 7;
  localparam int BIT_EP1_FULL  = 6;
  localparam int BIT_EP2_REQ   = 5;
  localparam int BIT_EP2_EMPTY = 4;
  localparam int BIT_SETUP     = 3;
  localparam int N_STICKY      = 3;
  localparam int N_LIVE        = 2;
  // sticky slot order: 0 setup, 1 ep2 request, 2 bus reset
  localparam int STK_SETUP     = 0;
  localparam int STK_EP2_REQ   = 1;
  localparam int STK_BUS_RST   = 2;
  // live slot order: 0 ep2 space, 1 ep1 full
  localparam int LIV_EP2_EMPTY = 0;
  localparam int LIV_EP1_FULL  = 1;
  localparam logic [N_LIVE-1:0] LIVE_RST = 2'b01;

  typedef enum logic {SEL_STATUS = 1'b0, SEL_MASK = 1'b1} reg_sel_e;
endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)           flag_q[i] <= 1'b0;
      else if (set_i[i]) flag_q[i] <= 1'b1;
      else if (clr_i[i]) flag_q[i] <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      set_i[i] |=> flag_q[i]); // R5
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
      (clr_i[i] && !set_i[i]) |=> !flag_q[i]); // R4
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (!clr_i[i] && !set_i[i]) |=> $stable(flag_q[i])); // R2
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_status_stage.sv
module irq_status_stage #(
  parameter int             N       = 2,
  parameter logic [N-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] stat_i,
  output logic [N-1:0] stat_o
);
  logic [N-1:0] stat_q;

  always_ff @(posedge clk) begin
    if (rst) stat_q <= RST_VAL;
    else     stat_q <= stat_i;
  end

  AST_LIVE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> stat_q == $past(stat_i)); // R6

  assign stat_o = stat_q;
endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pend_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_o
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(pend_i & mask_i);
  end

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (mask_i == '0) |=> !irq_q); // R9

  assign irq_o = irq_q;
endmodule

// File: rtl/usb_irq_flag_reg.sv
module usb_irq_flag_reg
  import usb_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_sel_i,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             ev_bus_reset_i,
  input  logic             ev_ep2_in_tok_i,
  input  logic             ep2_data_rdy_i,
  input  logic             ev_setup_i,
  input  logic             ep1_rx_full_i,
  input  logic             ep2_tx_space_i,
  output logic             irq_o
);
  logic                wr_status, wr_mask;
  logic [N_STICKY-1:0] stk_set, stk_clr, stk_q;
  logic [N_LIVE-1:0]   live_in, live_q;
  logic [REG_W-1:0]    status_view, mask_q, rd_q;

  assign wr_status = reg_wr_i && (reg_sel_e'(reg_sel_i) == SEL_STATUS);
  assign wr_mask   = reg_wr_i && (reg_sel_e'(reg_sel_i) == SEL_MASK);

  always_comb begin
    stk_set              = '0;
    stk_set[STK_SETUP]   = ev_setup_i;
    stk_set[STK_EP2_REQ] = ev_ep2_in_tok_i && !ep2_data_rdy_i;
    stk_set[STK_BUS_RST] = ev_bus_reset_i;
    stk_clr              = '0;
    stk_clr[STK_SETUP]   = wr_status && !reg_wdata_i[BIT_SETUP];
    stk_clr[STK_EP2_REQ] = wr_status && !reg_wdata_i[BIT_EP2_REQ];
    stk_clr[STK_BUS_RST] = wr_status && !reg_wdata_i[BIT_BUS_RST];
  end

  irq_sticky_bank #(.N(N_STICKY)) i_sticky (
    .clk(clk), .rst(rst), .set_i(stk_set), .clr_i(stk_clr), .flag_o(stk_q)
  );

  always_comb begin
    live_in                = '0;
    live_in[LIV_EP2_EMPTY] = ep2_tx_space_i;
    live_in[LIV_EP1_FULL]  = ep1_rx_full_i;
  end

  irq_status_stage #(.N(N_LIVE), .RST_VAL(LIVE_RST)) i_live (
    .clk(clk), .rst(rst), .stat_i(live_in), .stat_o(live_q)
  );

  always_comb begin
    status_view                = '0;
    status_view[BIT_BUS_RST]   = stk_q[STK_BUS_RST];
    status_view[BIT_EP1_FULL]  = live_q[LIV_EP1_FULL];
    status_view[BIT_EP2_REQ]   = stk_q[STK_EP2_REQ];
    status_view[BIT_EP2_EMPTY] = live_q[LIV_EP2_EMPTY];
    status_view[BIT_SETUP]     = stk_q[STK_SETUP];
  end

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '0;
    else if (wr_mask) mask_q <= reg_wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst)            rd_q <= '0;
    else if (reg_sel_i) rd_q <= mask_q;
    else                rd_q <= status_view;
  end

  irq_req_gen #(.W(REG_W)) i_req (
    .clk(clk), .rst(rst), .pend_i(status_view), .mask_i(mask_q), .irq_o(irq_o)
  );

  assign rd_data_o = rd_q;

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    !reg_sel_i |=> rd_q[BIT_SETUP-1:0] == '0); // R7
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
    wr_mask |=> mask_q == $past(reg_wdata_i)); // R8
  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (rst)
    ((status_view & mask_q) == '0) |=> !irq_o); // R9
endmodule

// File: tb/test_usb_irq_flag_reg.sv
module test_usb_irq_flag_reg;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel = 1'b0, wr = 1'b0;
  logic [7:0] wd = '0;
  logic [7:0] rd;
  logic       ev_br = 0, ev_tok = 0, rdy = 0, ev_su = 0, full = 0, space = 1;
  logic       irq;

  int    n_vec = 0, n_bad = 0;
  bit    done  = 0;
  string cur_req = "R1";

  // behavioural model state
  bit       m_br, m_req, m_su, m_full, m_space, m_irq;
  bit [7:0] m_en, m_rd;

  always #2.5 clk = ~clk;

  usb_irq_flag_reg i_usb_irq_flag_reg (
    .clk(clk), .rst(rst), .reg_sel_i(sel), .reg_wr_i(wr), .reg_wdata_i(wd),
    .rd_data_o(rd), .ev_bus_reset_i(ev_br), .ev_ep2_in_tok_i(ev_tok),
    .ep2_data_rdy_i(rdy), .ev_setup_i(ev_su), .ep1_rx_full_i(full),
    .ep2_tx_space_i(space), .irq_o(irq)
  );

  function automatic bit [7:0] view();
    return {m_br, m_full, m_req, m_space, m_su, 3'b000};
  endfunction

  task automatic model_edge();
    bit [7:0] v = view();
    if (rst) begin
      {m_br, m_req, m_su, m_full, m_irq} = '0;
      m_space = 1; m_en = 8'h00; m_rd = 8'h00;
    end else begin
      m_rd  = sel ? m_en : v;
      m_irq = |(v & m_en);
      m_br  = ev_br | (m_br & !(wr && !sel && !wd[7]));
      m_su  = ev_su | (m_su & !(wr && !sel && !wd[3]));
      m_req = (ev_tok & !rdy) | (m_req & !(wr && !sel && !wd[5]));
      m_full = full; m_space = space;
      if (wr && sel) m_en = wd;
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    n_vec++;
    if (rd !== m_rd || irq !== m_irq) begin
      n_bad++;
      $display("FAIL %s: rd=%h irq=%b expected rd=%h irq=%b", cur_req, rd, irq, m_rd, m_irq);
    end
    ev_br = 0; ev_tok = 0; ev_su = 0; wr = 0;
  endtask

  task automatic wr_reg(input bit s, input bit [7:0] d);
    sel = s; wr = 1; wd = d; step();
  endtask

  task automatic rd_reg(input bit s);
    sel = s; step();
  endtask

  initial begin
    #(5 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: rd=%h irq=%b expected completion", rd, irq);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cur_req = "R1"; step(); step(); rst = 0;
    rd_reg(0); rd_reg(1); rd_reg(0);                 // R1 reset values 0x10 / 0x00
    cur_req = "R8"; wr_reg(1, 8'hA5); rd_reg(1); rd_reg(1);
    wr_reg(1, 8'h00); rd_reg(1);
    cur_req = "R2"; ev_br = 1; rd_reg(0); rd_reg(0); rd_reg(0);
    ev_su = 1; rd_reg(0); rd_reg(0); rd_reg(0);
    cur_req = "R3"; rdy = 1; ev_tok = 1; rd_reg(0); rd_reg(0);
    rdy = 0; ev_tok = 1; rd_reg(0); rd_reg(0);
    cur_req = "R4"; wr_reg(0, 8'hFF); rd_reg(0);
    wr_reg(0, 8'h7F); rd_reg(0); wr_reg(0, 8'hD7); rd_reg(0);
    wr_reg(0, 8'hF7); rd_reg(0);
    cur_req = "R5"; ev_br = 1; ev_su = 1; ev_tok = 1; wr_reg(0, 8'h00); rd_reg(0); rd_reg(0);
    wr_reg(0, 8'h00); rd_reg(0);
    cur_req = "R6"; full = 1; space = 0; rd_reg(0); rd_reg(0);
    wr_reg(0, 8'h00); rd_reg(0); wr_reg(0, 8'hFF); rd_reg(0);
    full = 0; space = 1; rd_reg(0); rd_reg(0);
    cur_req = "R7"; wr_reg(0, 8'h07); rd_reg(0); rd_reg(0);
    cur_req = "R9"; wr_reg(1, 8'h80); rd_reg(0); ev_br = 1; rd_reg(0); rd_reg(0); rd_reg(0);
    wr_reg(0, 8'h7F); rd_reg(0); rd_reg(0);
    wr_reg(1, 8'h10); rd_reg(0); rd_reg(0); space = 0; rd_reg(0); rd_reg(0); rd_reg(0);
    cur_req = "R10";
    for (int i = 0; i < 3000; i++) begin
      sel    = $urandom_range(0, 1);
      wr     = ($urandom_range(0, 3) == 0);
      wd     = 8'($urandom);
      ev_br  = ($urandom_range(0, 7) == 0);
      ev_su  = ($urandom_range(0, 7) == 0);
      ev_tok = ($urandom_range(0, 3) == 0);
      rdy    = $urandom_range(0, 1);
      full   = $urandom_range(0, 1);
      space  = $urandom_range(0, 1);
      step();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule